// File: doc/BRIEF.md
# USB General Transfer Descriptor Service Engine

This block services one general (non-isochronous) transfer descriptor of a USB host controller against the endpoint that owns it. A list walker hands it the endpoint's function address, endpoint number, maximum packet size and toggle carry, together with the descriptor's flag word, current buffer pointer and buffer end. The engine works out the remaining length and the size of the packet to move now. It raises a token request toward the device side and waits for the reply.

The reply is a signed byte count, where a negative value carries an error code. From it the engine produces the updated flag word: condition code, error count and data toggle. It also produces the new buffer pointer and the new endpoint toggle carry. It decides whether the descriptor is retired and keeps a done-queue interrupt delay counter that only ever moves down.

An OUT or SETUP transfer longer than the endpoint's maximum packet size is cut into packets of at most that size. Each packet returns an updated, unretired descriptor, and the descriptor retires only when the last chunk completes. Descriptor fetch and write-back, isochronous work and list walking belong to the surrounding logic.

Top module: `td_service_engine`

## Requirements
- R1: After reset, `done`, `tok_req` and `busy` are low and `dly_cnt` is 7.
- R2: The direction is `td_flags[20:19]`, with 0 meaning SETUP, 1 OUT and 2 IN; code 3 is handled as OUT, and `tok_pid` carries the code. The remaining length is `td_be - td_cbp + 1`, kept to 14 bits, when `td_cbp` is nonzero, and 0 otherwise. `tok_len` is the whole remaining length for IN and the smaller of `ed_mps` and the remaining length for the other directions. `tok_addr` and `tok_ep` carry the endpoint's address and number.
- R3: A `start` while idle makes `tok_req` and `busy` high from the next cycle until the edge where `rsp_valid` is seen. `done` is high for exactly the one cycle after that edge, with results on `out_*`, `retire` and `err`.
- R4: A reply succeeds when it equals `tok_len`, or when the direction is IN, the rounding bit `td_flags[18]` is set and the reply is in 0..`tok_len`. On success the condition code (`[31:28]`) becomes 0 and the error count (`[27:26]`) becomes 0.
- R5: The toggle in use, shown on `tok_toggle`, is `td_flags[24]` when `td_flags[25]` is set, and `ed_carry` otherwise. On success the output sets bit 25 and writes the inverse of the used toggle to bit 24; on any other outcome bits 25:24 are unchanged.
- R6: On success, `out_cbp` is 0 when the reply equals the full remaining length, and `td_cbp` plus the reply otherwise.
- R7: A successful non-IN packet shorter than the full remaining length does not retire the descriptor. A successful IN reply always retires it.
- R8: `out_carry` equals output bit 24 when the descriptor retires and `ed_carry` when it does not.
- R9: On each retirement `dly_cnt` takes the delay field `td_flags[23:21]` if that value is lower than `dly_cnt`; otherwise it holds.
- R10: A non-negative reply above `tok_len` gives condition code 8, and a reply below `tok_len` that is not a success gives condition code 9. Both clear the error count and retire the descriptor.
- R11: A negative reply of -1..-15 writes its magnitude as the condition code and raises the error count by one, saturating at 3. The descriptor retires only when the count reaches 3.
- R12: `err` is high exactly when the output condition code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin servicing the presented descriptor |
| ed_fa | input | 7 | Endpoint function address |
| ed_en | input | 4 | Endpoint number |
| ed_mps | input | MPS_W | Endpoint maximum packet size |
| ed_carry | input | 1 | Endpoint toggle carry |
| td_flags | input | 32 | Descriptor flag word |
| td_cbp | input | ADDR_W | Current buffer pointer |
| td_be | input | ADDR_W | Buffer end address |
| busy | output | 1 | A packet is outstanding |
| tok_req | output | 1 | Token request to the device side |
| tok_pid | output | 2 | Token kind: 0 SETUP, 1 OUT, 2 IN |
| tok_addr | output | 7 | Token function address |
| tok_ep | output | 4 | Token endpoint number |
| tok_len | output | LEN_W | Bytes requested for this packet |
| tok_toggle | output | 1 | Data toggle used for this packet |
| rsp_valid | input | 1 | Device reply present |
| rsp_count | input | CNT_W | Signed reply: byte count, or negated error code |
| done | output | 1 | One-cycle result strobe |
| retire | output | 1 | Descriptor is retired |
| err | output | 1 | Output condition code is nonzero |
| out_flags | output | 32 | Updated flag word |
| out_cbp | output | ADDR_W | Updated buffer pointer |
| out_carry | output | 1 | Updated endpoint toggle carry |
| dly_cnt | output | 3 | Done-queue interrupt delay counter |

## Verification
A wrong latched length or pointer shows on `tok_len` in the first cycle of the request and on `out_cbp` in the `done` cycle of the same descriptor. A bad toggle shows right away on `tok_toggle` and again in bits 25:24 of `out_flags`. A corrupted delay counter shows on `dly_cnt` one cycle after the retirement that should have moved it, and it stays visible because the counter never rises. A stuck state machine shows as a missing or repeated `done` within one cycle of the reply.

// File: rtl/tdse_pkg.sv
package tdse_pkg;
    localparam int TOG0_BIT  = 24;
    localparam int TOG1_BIT  = 25;
    localparam int ERRC_LO   = 26;
    localparam int CCODE_LO  = 28;
    localparam int DLY_LO    = 21;
    localparam int DIR_LO    = 19;
    localparam int ROUND_BIT = 18;

    localparam logic [3:0] CC_OK    = 4'h0;
    localparam logic [3:0] CC_OVER  = 4'h8;
    localparam logic [3:0] CC_UNDER = 4'h9;

    typedef enum logic [1:0] {
        KIND_SETUP = 2'd0,
        KIND_OUT   = 2'd1,
        KIND_IN    = 2'd2
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } st_e;
endpackage

// File: rtl/tdse_len.sv
module tdse_len #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 14,
    parameter int MPS_W  = 11
) (
    input  logic [ADDR_W-1:0] cbp,
    input  logic [ADDR_W-1:0] be,
    input  logic [MPS_W-1:0]  mps,
    input  logic              is_in,
    output logic [LEN_W-1:0]  total,
    output logic [LEN_W-1:0]  chunk
);
    localparam int MX_W = (LEN_W > MPS_W) ? LEN_W : MPS_W;

    logic [ADDR_W-1:0] span;
    logic [MX_W-1:0]   mps_x;
    logic [MX_W-1:0]   tot_x;

    always_comb begin
        span  = be - cbp + {{(ADDR_W-1){1'b0}}, 1'b1};
        total = (cbp != '0) ? span[LEN_W-1:0] : '0;
        mps_x = MX_W'(mps);
        tot_x = MX_W'(total);
        if (is_in || (tot_x <= mps_x)) begin
            chunk = total;
        end else begin
            chunk = LEN_W'(mps_x);
        end
    end
endmodule

// File: rtl/tdse_eval.sv
module tdse_eval
    import tdse_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 14,
    parameter int CNT_W  = 16
) (
    input  logic              is_in,
    input  logic [LEN_W-1:0]  total,
    input  logic [LEN_W-1:0]  chunk,
    input  logic [CNT_W-1:0]  count,
    input  logic [31:0]       flags,
    input  logic [ADDR_W-1:0] cbp,
    input  logic              carry_in,
    output logic              tog_used,
    output logic [31:0]       flags_o,
    output logic [ADDR_W-1:0] cbp_o,
    output logic              carry_o,
    output logic              retire_o,
    output logic              err_o
);
    logic signed [CNT_W-1:0] cnt_s;
    logic signed [CNT_W-1:0] chunk_s;
    logic signed [CNT_W-1:0] total_s;
    logic        [CNT_W-1:0] mag;
    logic        [1:0]       ec_in;
    logic        [1:0]       ec_nx;
    logic                    good;

    always_comb begin
        cnt_s    = $signed(count);
        chunk_s  = $signed(CNT_W'(chunk));
        total_s  = $signed(CNT_W'(total));
        mag      = -count;
        ec_in    = flags[ERRC_LO +: 2];
        ec_nx    = (ec_in >= 2'd2) ? 2'd3 : ec_in + 2'd1;
        tog_used = flags[TOG1_BIT] ? flags[TOG0_BIT] : carry_in;
        good     = (cnt_s == chunk_s) || (is_in && flags[ROUND_BIT] && (cnt_s >= 0));

        flags_o  = flags;
        cbp_o    = cbp;
        retire_o = 1'b0;

        if (cnt_s < 0) begin
            flags_o[ERRC_LO +: 2]  = ec_nx;
            flags_o[CCODE_LO +: 4] = mag[3:0];
            retire_o               = (ec_nx == 2'd3);
        end else if (cnt_s > chunk_s) begin
            flags_o[ERRC_LO +: 2]  = 2'd0;
            flags_o[CCODE_LO +: 4] = CC_OVER;
            retire_o               = 1'b1;
        end else if (good) begin
            flags_o[ERRC_LO +: 2]  = 2'd0;
            flags_o[CCODE_LO +: 4] = CC_OK;
            flags_o[TOG1_BIT]      = 1'b1;
            flags_o[TOG0_BIT]      = ~tog_used;
            if (cnt_s == total_s) begin
                cbp_o = '0;
            end else begin
                cbp_o = cbp + ADDR_W'(count);
            end
            retire_o = is_in || (cnt_s == total_s);
        end else begin
            flags_o[ERRC_LO +: 2]  = 2'd0;
            flags_o[CCODE_LO +: 4] = CC_UNDER;
            retire_o               = 1'b1;
        end

        carry_o = retire_o ? flags_o[TOG0_BIT] : carry_in;
        err_o   = (flags_o[CCODE_LO +: 4] != CC_OK);
    end
endmodule

// File: rtl/td_service_engine.sv
module td_service_engine
    import tdse_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 14,
    parameter int MPS_W  = 11,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [6:0]        ed_fa,
    input  logic [3:0]        ed_en,
    input  logic [MPS_W-1:0]  ed_mps,
    input  logic              ed_carry,
    input  logic [31:0]       td_flags,
    input  logic [ADDR_W-1:0] td_cbp,
    input  logic [ADDR_W-1:0] td_be,
    output logic              busy,
    output logic              tok_req,
    output logic [1:0]        tok_pid,
    output logic [6:0]        tok_addr,
    output logic [3:0]        tok_ep,
    output logic [LEN_W-1:0]  tok_len,
    output logic              tok_toggle,
    input  logic              rsp_valid,
    input  logic [CNT_W-1:0]  rsp_count,
    output logic              done,
    output logic              retire,
    output logic              err,
    output logic [31:0]       out_flags,
    output logic [ADDR_W-1:0] out_cbp,
    output logic              out_carry,
    output logic [2:0]        dly_cnt
);
    typedef struct packed {
        st_e               st;
        logic [6:0]        fa;
        logic [3:0]        ep;
        logic [31:0]       flags;
        logic [ADDR_W-1:0] cbp;
        logic              carry;
        logic [LEN_W-1:0]  total;
        logic [LEN_W-1:0]  chunk;
        logic              done;
        logic              retire;
        logic              err;
        logic [31:0]       oflags;
        logic [ADDR_W-1:0] ocbp;
        logic              ocarry;
        logic [2:0]        dly;
    } eng_t;

    eng_t r_q, r_d;

    logic [1:0]        kind_in;
    logic              start_is_in;
    logic [LEN_W-1:0]  total_w;
    logic [LEN_W-1:0]  chunk_w;
    logic              held_is_in;
    logic              tog_w;
    logic [31:0]       flags_w;
    logic [ADDR_W-1:0] cbp_w;
    logic              carry_w;
    logic              retire_w;
    logic              err_w;
    logic [2:0]        di_w;

    assign kind_in     = td_flags[DIR_LO +: 2];
    assign start_is_in = (kind_in == KIND_IN);
    assign held_is_in  = (r_q.flags[DIR_LO +: 2] == KIND_IN);
    assign di_w        = r_q.flags[DLY_LO +: 3];

    tdse_len #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .MPS_W  (MPS_W)
    ) u_len (
        .cbp    (td_cbp),
        .be     (td_be),
        .mps    (ed_mps),
        .is_in  (start_is_in),
        .total  (total_w),
        .chunk  (chunk_w)
    );

    tdse_eval #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W)
    ) u_eval (
        .is_in    (held_is_in),
        .total    (r_q.total),
        .chunk    (r_q.chunk),
        .count    (rsp_count),
        .flags    (r_q.flags),
        .cbp      (r_q.cbp),
        .carry_in (r_q.carry),
        .tog_used (tog_w),
        .flags_o  (flags_w),
        .cbp_o    (cbp_w),
        .carry_o  (carry_w),
        .retire_o (retire_w),
        .err_o    (err_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_WAIT;
                    r_d.fa    = ed_fa;
                    r_d.ep    = ed_en;
                    r_d.flags = td_flags;
                    r_d.cbp   = td_cbp;
                    r_d.carry = ed_carry;
                    r_d.total = total_w;
                    r_d.chunk = chunk_w;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    r_d.st     = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.retire = retire_w;
                    r_d.err    = err_w;
                    r_d.oflags = flags_w;
                    r_d.ocbp   = cbp_w;
                    r_d.ocarry = carry_w;
                    if (retire_w && (di_w < r_q.dly)) begin
                        r_d.dly = di_w;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.dly <= 3'd7;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st == ST_WAIT);
    assign tok_req    = (r_q.st == ST_WAIT);
    assign tok_pid    = (r_q.flags[DIR_LO +: 2] == 2'd3) ? KIND_OUT : r_q.flags[DIR_LO +: 2];
    assign tok_addr   = r_q.fa;
    assign tok_ep     = r_q.ep;
    assign tok_len    = r_q.chunk;
    assign tok_toggle = tog_w;
    assign done       = r_q.done;
    assign retire     = r_q.retire;
    assign err        = r_q.err;
    assign out_flags  = r_q.oflags;
    assign out_cbp    = r_q.ocbp;
    assign out_carry  = r_q.ocarry;
    assign dly_cnt    = r_q.dly;
endmodule

// File: rtl/tdse_chk.sv
module tdse_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              tok_req,
    input logic              rsp_valid,
    input logic              done,
    input logic              retire,
    input logic              err,
    input logic [31:0]       out_flags,
    input logic [ADDR_W-1:0] out_cbp,
    input logic [2:0]        dly_cnt
);
    // R3
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> tok_req);
    // R3
    reply_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_req && rsp_valid |=> done && !tok_req);
    // R3
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tok_req) && $past(rsp_valid));
    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    dly_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_cnt <= $past(dly_cnt));
    // R12
    err_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == (out_flags[31:28] != 4'h0)));
    // R7
    partial_cbp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !retire && (out_flags[31:28] == 4'h0) |-> (out_cbp != '0));
endmodule

bind td_service_engine tdse_chk #(.ADDR_W(ADDR_W)) u_tdse_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .tok_req   (tok_req),
    .rsp_valid (rsp_valid),
    .done      (done),
    .retire    (retire),
    .err       (err),
    .out_flags (out_flags),
    .out_cbp   (out_cbp),
    .dly_cnt   (dly_cnt)
);

// File: tb/td_service_engine_bench.sv
module td_service_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  ed_fa = '0;
    logic [3:0]  ed_en = '0;
    logic [10:0] ed_mps = '0;
    logic        ed_carry = 1'b0;
    logic [31:0] td_flags = '0;
    logic [31:0] td_cbp = '0;
    logic [31:0] td_be = '0;
    logic        busy, tok_req, tok_toggle;
    logic [1:0]  tok_pid;
    logic [6:0]  tok_addr;
    logic [3:0]  tok_ep;
    logic [13:0] tok_len;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_count = '0;
    logic        done, retire, err, out_carry;
    logic [31:0] out_flags, out_cbp;
    logic [2:0]  dly_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    td_service_engine u_td_service_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ed_fa(ed_fa), .ed_en(ed_en), .ed_mps(ed_mps), .ed_carry(ed_carry),
        .td_flags(td_flags), .td_cbp(td_cbp), .td_be(td_be),
        .busy(busy), .tok_req(tok_req), .tok_pid(tok_pid), .tok_addr(tok_addr),
        .tok_ep(tok_ep), .tok_len(tok_len), .tok_toggle(tok_toggle),
        .rsp_valid(rsp_valid), .rsp_count(rsp_count),
        .done(done), .retire(retire), .err(err), .out_flags(out_flags),
        .out_cbp(out_cbp), .out_carry(out_carry), .dly_cnt(dly_cnt)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] fl, input logic [31:0] cbp, input logic [31:0] be,
                         input int mps, input bit car, input int cnt,
                         output int len, output int pkt, output logic [31:0] fo,
                         output logic [31:0] cbpo, output bit reto, output bit caro,
                         output bit erro, output bit tog);
        bit isin;
        bit rnd;
        int ec;
        int ecn;
        isin = (fl[20:19] == 2'd2);
        rnd  = fl[18];
        len  = (cbp != 0) ? int'((be - cbp + 32'd1) & 32'h3FFF) : 0;
        pkt  = isin ? len : ((mps < len) ? mps : len);
        tog  = fl[25] ? fl[24] : car;
        fo   = fl;
        cbpo = cbp;
        reto = 1'b0;
        if (cnt < 0) begin
            ec  = int'(fl[27:26]);
            ecn = (ec >= 2) ? 3 : ec + 1;
            fo[27:26] = 2'(ecn);
            fo[31:28] = 4'((-cnt) & 15);
            reto = (ecn == 3);
        end else if (cnt > pkt) begin
            fo[27:26] = 2'd0; fo[31:28] = 4'h8; reto = 1'b1;
        end else if (cnt == pkt || (isin && rnd)) begin
            fo[27:26] = 2'd0; fo[31:28] = 4'h0;
            fo[25] = 1'b1; fo[24] = ~tog;
            cbpo = (cnt == len) ? 32'd0 : cbp + 32'(cnt);
            reto = isin || (cnt == len);
        end else begin
            fo[27:26] = 2'd0; fo[31:28] = 4'h9; reto = 1'b1;
        end
        caro = reto ? fo[24] : car;
        erro = (fo[31:28] != 4'h0);
    endtask

    task automatic run(input logic [31:0] fl, input logic [31:0] cbp, input logic [31:0] be,
                       input int mps, input bit car, input int cnt, input int wait_n);
        int len, pkt;
        logic [31:0] fo, cbpo;
        bit reto, caro, erro, tog;
        logic [1:0] pid;
        model(fl, cbp, be, mps, car, cnt, len, pkt, fo, cbpo, reto, caro, erro, tog);
        pid = (fl[20:19] == 2'd3) ? 2'd1 : fl[20:19];
        @(negedge clk);
        td_flags = fl; td_cbp = cbp; td_be = be; ed_mps = 11'(mps); ed_carry = car;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        td_flags = ~fl; td_cbp = '1; ed_carry = ~car;
        chk(tok_req && busy, "R3 request raised", {62'd0, tok_req, busy}, 64'd3);
        chk(tok_len == 14'(pkt), "R2 packet length", 64'(tok_len), 64'(pkt));
        chk(tok_pid == pid, "R2 token kind", 64'(tok_pid), 64'(pid));
        chk(tok_toggle == tog, "R5 toggle used", 64'(tok_toggle), 64'(tog));
        repeat (wait_n) @(negedge clk);
        chk(tok_req && !done, "R3 still waiting", {62'd0, tok_req, done}, 64'd2);
        rsp_valid = 1'b1; rsp_count = 16'(cnt);
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(done && !tok_req, "R3 done strobe", {62'd0, done, tok_req}, 64'd2);
        chk(out_flags[31:26] == fo[31:26], "R4 R10 R11 cc and error count",
            64'(out_flags[31:26]), 64'(fo[31:26]));
        chk(out_flags[25:24] == fo[25:24] && out_flags[23:0] == fo[23:0], "R5 toggle bits",
            64'(out_flags), 64'(fo));
        chk(out_cbp == cbpo, "R6 buffer pointer", 64'(out_cbp), 64'(cbpo));
        chk(retire == reto, "R7 retire decision", 64'(retire), 64'(reto));
        chk(out_carry == caro, "R8 toggle carry", 64'(out_carry), 64'(caro));
        chk(err == erro, "R12 error flag", 64'(err), 64'(erro));
        @(negedge clk);
        chk(!done, "R3 single-cycle done", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int lens[6] = '{0, 1, 7, 8, 9, 20};
        int idx = 0;
        repeat (3) @(negedge clk);
        chk(!done && !tok_req && !busy, "R1 reset outputs", {61'd0, done, tok_req, busy}, 64'd0);
        chk(dly_cnt == 3'd7, "R1 reset delay", 64'(dly_cnt), 64'd7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dly_cnt == 3'd7 && !busy, "R1 after release", 64'(dly_cnt), 64'd7);

        ed_fa = 7'h2B; ed_en = 4'hA;
        @(negedge clk);
        start = 1'b1; td_flags = 32'h00E8_0000; td_cbp = 32'h10; td_be = 32'h13; ed_mps = 11'd8;
        @(negedge clk);
        start = 1'b0;
        chk(tok_addr == 7'h2B && tok_ep == 4'hA, "R2 address and endpoint",
            {53'd0, tok_addr, tok_ep}, {53'd0, 7'h2B, 4'hA});
        rsp_valid = 1'b1; rsp_count = 16'd4;
        @(negedge clk);
        rsp_valid = 1'b0;
        @(negedge clk);

        for (int dir = 0; dir < 4; dir++) begin
            for (int li = 0; li < 6; li++) begin
                for (int md = 0; md < 4; md++) begin
                    for (int rnd = 0; rnd < 2; rnd++) begin
                        logic [31:0] fl, cbp, be;
                        int len, pkt, cnt;
                        len = lens[li];
                        cbp = (len == 0) ? 32'd0 : 32'h1000 + 32'(idx * 64);
                        be  = (len == 0) ? 32'd0 : cbp + 32'(len) - 32'd1;
                        pkt = (dir == 2) ? len : ((len < 8) ? len : 8);
                        fl  = (32'(dir) << 19) | (32'(rnd) << 18) | (32'd7 << 21)
                            | (32'(idx % 4) << 24) | (32'((idx / 4) % 4) << 26) | 32'h0000_1234;
                        case (md)
                            0: cnt = pkt;
                            1: cnt = pkt - 1;
                            2: cnt = pkt + 1;
                            default: cnt = -(3 + (idx % 3));
                        endcase
                        run(fl, cbp, be, 8, idx[2], cnt, idx % 2);
                        idx++;
                    end
                end
            end
        end
        chk(dly_cnt == 3'd7, "R9 delay unchanged by value 7", 64'(dly_cnt), 64'd7);

        // R9: lowering only when smaller, only on retirement
        run((32'd2 << 19) | (32'd5 << 21), 32'h2000, 32'h2003, 8, 1'b0, 4, 0);
        chk(dly_cnt == 3'd5, "R9 lowered to 5", 64'(dly_cnt), 64'd5);
        run((32'd2 << 19) | (32'd6 << 21), 32'h2000, 32'h2003, 8, 1'b0, 4, 0);
        chk(dly_cnt == 3'd5, "R9 larger value ignored", 64'(dly_cnt), 64'd5);
        run((32'd1 << 19) | (32'd1 << 21), 32'h2000, 32'h2013, 8, 1'b0, 8, 1);
        chk(dly_cnt == 3'd5, "R9 no change without retire", 64'(dly_cnt), 64'd5);
        run((32'd1 << 19) | (32'd2 << 21), 32'h2000, 32'h2003, 8, 1'b0, -2, 0);
        chk(dly_cnt == 3'd5, "R9 R11 first error keeps delay", 64'(dly_cnt), 64'd5);
        run((32'd0 << 19) | (32'd2 << 21), 32'h2000, 32'h2003, 8, 1'b0, 4, 0);
        chk(dly_cnt == 3'd2, "R9 lowered to 2", 64'(dly_cnt), 64'd2);

        // R7: split OUT transfer of 20 bytes with max packet 8
        run((32'd1 << 19) | (32'd7 << 21), 32'h3000, 32'h3013, 8, 1'b1, 8, 0);
        run((32'd1 << 19) | (32'd7 << 21) | (32'h3 << 24) | (32'h0 << 24), 32'h3008, 32'h3013, 8, 1'b1, 8, 1);
        run((32'd1 << 19) | (32'd7 << 21) | (32'h2 << 24), 32'h3010, 32'h3013, 8, 1'b1, 4, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule